// File: doc/BRIEF.md
# Paged PHY Configuration Register File

This block is the configuration and status register file of a multi-port serial-bus physical layer. It offers sixteen byte-wide locations through a plain single-cycle read/write interface with a 4-bit address. Locations 0 to 7 are fixed. Locations 8 to 15 are a window. A page number and a port number, both held in location 7, choose what the window shows. Page 0 shows the line and connection status of the selected port. Page 1 shows fixed identification bytes.

The core supplies status to the block: node identity, root flag, cable power, and per-port line states, connection, bias, disabled, fault, speed and resume-start. The block holds the gap count, the link-control, contender and power-class settings, and a group of sticky interrupt flags. Each flag is cleared by writing a one to it. The block also raises a port-event interrupt when enabled per-port status changes. A small command state machine turns the two reset-command bits into single-cycle request pulses. Its states are `CMD_IDLE`, `CMD_LONG` and `CMD_SHORT`. A write of the long-reset bit moves it to `CMD_LONG`. A write of the short-reset bit moves it to `CMD_SHORT`. With no command write it returns to `CMD_IDLE` on the next clock.

Bit numbering in the tables below is plain: bit 7 is the most significant bit, and it is the first bit in the register's documented order. Reads are combinational from `addr`. A write takes effect at the clock edge where `wr_en` is high.

Top module: `phy_cfg_regfile`

## Requirements
- R1: After reset, location 1 reads 0x3F, location 5 reads 0x20 (only the power-fail flag set), location 7 reads 0x00, and location 4 reads {0, strap contender, 000, strap power class}.
- R2: Location 0 reads {node_id[5:0], is_root, cable_pwr}. Location 2 reads {3'b111, 5-bit port count} (0xE3 for three ports). Location 3 reads 0x40 (maximum speed code 010 in bits 7:5). Location 6 reads 0.
- R3: The gap count is bits 5:0 of location 1. It is read/write, reset value 0x3F, and drives `gap_count`. Bit 6 of location 1 reads 0.
- R4: Writing 1 to bit 7 of location 1 raises `bus_reset_req` for exactly the one cycle after the write. Writing 1 to bit 7 of location 5 raises `short_reset_req` the same way. The two requests are never high together, and both bits read 0 once the pulse is over.
- R5: Location 4 holds link-control (bit 7), contender (bit 6) and power class (bits 2:0). All three are read/write. `link_active` is high only when link-control is 1 and `lps` is 1.
- R6: The power-fail flag (location 5 bit 5) is set in the cycle after `cable_pwr` falls from 1 to 0. Writing a 1 to that bit clears it.
- R7: The loop flag (bit 6) and timeout flag (bit 4) of location 5 are set by a pulse on `loop_evt` or `timeout_evt`. Writing a 1 clears a flag, and writing a 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the flag stays set.
- R8: Location 7 holds the page select in bits 7:5 and the port select in bits 3:0. Both are read/write.
- R9: On page 0, location 8 reads {A line[1:0], B line[1:0], child, connected, bias, disabled} of the selected port. Location 9 reads {speed[2:0], interrupt enable, fault, 000}. Line codes pass through unchanged: 00 invalid, 01 one, 10 zero, 11 high-impedance.
- R10: The per-port interrupt enable is location 9 bit 4 on page 0, and it is read/write. The fault flag, location 9 bit 3, is set on a rising `port_fault` and cleared by writing a 1 to it.
- R11: The port-event flag (location 5 bit 3) is set when the connected, bias, disabled or fault input changes on any port whose interrupt enable is 1. It is also set by a resume-start pulse on any port while the resume-interrupt enable (location 5 bit 2, read/write) is 1. Changes on ports whose interrupt enable is 0 have no effect. Writing a 1 clears the flag.
- R12: On page 1, location 8 reads 0x01 and location 9 reads 0. Locations 10 to 12 read the vendor identifier, most significant byte first. Locations 13 to 15 read the product identifier, most significant byte first.
- R13: The window reads 0 when the port select is at or above the port count on page 0, and on any page other than 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, held for at least one clock |
| addr | input | 4 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| node_id | input | 6 | Node identifier from the core |
| is_root | input | 1 | Root flag from the core |
| cable_pwr | input | 1 | Cable power present |
| lps | input | 1 | Link power status |
| strap_contender | input | 1 | Power-on contender value |
| strap_pwr_class | input | 3 | Power-on power class |
| loop_evt | input | 1 | Loop-detected pulse |
| timeout_evt | input | 1 | Arbitration-timeout pulse |
| port_a_line | input | 2*NUM_PORTS | A-pair line state per port |
| port_b_line | input | 2*NUM_PORTS | B-pair line state per port |
| port_child | input | NUM_PORTS | Child flag per port |
| port_conn | input | NUM_PORTS | Connected flag per port |
| port_bias | input | NUM_PORTS | Bias-detected flag per port |
| port_dis | input | NUM_PORTS | Disabled flag per port |
| port_fault | input | NUM_PORTS | Fault flag per port |
| port_speed | input | 3*NUM_PORTS | Negotiated speed per port |
| port_resume | input | NUM_PORTS | Resume-start pulse per port |
| gap_count | output | 6 | Current gap count |
| contender | output | 1 | Contender setting |
| pwr_class | output | 3 | Power-class setting |
| link_active | output | 1 | Link-active bit for transmission |
| bus_reset_req | output | 1 | Long bus reset request pulse |
| short_reset_req | output | 1 | Short arbitrated reset request pulse |
| irq_port_event | output | 1 | Port-event flag |
| irq_pwr_fail | output | 1 | Power-fail flag |
| irq_loop | output | 1 | Loop flag |
| irq_timeout | output | 1 | Timeout flag |

## Verification
The assertions check on every cycle that the two reset requests are never high together and that each follows its command write. They also check that a cable-power fall sets the power-fail flag, that loop and fault pulses are latched, that a clear write with no competing cause drops the port-event flag, and that the gap count holds without a write. Only the bench's scenarios can show the register layout: byte positions, the window contents for each page and port, the identification bytes, and that ports without an interrupt enable raise no event.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_LONG  = 2'd1,
        CMD_SHORT = 2'd2
    } cmd_state_e;

    localparam logic [3:0] A_IDENT = 4'd0;
    localparam logic [3:0] A_GAP   = 4'd1;
    localparam logic [3:0] A_CAPS  = 4'd2;
    localparam logic [3:0] A_SPEED = 4'd3;
    localparam logic [3:0] A_LINK  = 4'd4;
    localparam logic [3:0] A_IRQ   = 4'd5;
    localparam logic [3:0] A_SEL   = 4'd7;
    localparam logic [3:0] A_WIN9  = 4'd9;
endpackage

// File: rtl/phyreg_cmd_fsm.sv
module phyreg_cmd_fsm
    import phyreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic long_wr,
    input  logic short_wr,
    output logic long_req,
    output logic short_req
);
    cmd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = CMD_IDLE;
        unique case (state_q)
            CMD_IDLE, CMD_LONG, CMD_SHORT: begin
                if (long_wr)       state_d = CMD_LONG;
                else if (short_wr) state_d = CMD_SHORT;
                else               state_d = CMD_IDLE;
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    always_comb begin
        long_req  = 1'b0;
        short_req = 1'b0;
        unique case (state_q)
            CMD_LONG:  long_req  = 1'b1;
            CMD_SHORT: short_req = 1'b1;
            default: ;
        endcase
    end

    a_r4_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({long_req, short_req}));
    a_r4_long_follows: assert property (@(posedge clk) disable iff (!rst_n)
        long_wr |=> long_req);
    a_r4_short_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (short_wr && !long_wr) |=> short_req);
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (long_req && !long_wr) |=> !long_req);
endmodule

// File: rtl/phyreg_port_slot.sv
module phyreg_port_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic conn,
    input  logic bias,
    input  logic dis,
    input  logic fault,
    input  logic en_wr,
    input  logic en_val,
    input  logic fault_clr,
    output logic int_en,
    output logic fault_lat,
    output logic chg_evt
);
    logic [3:0] seen_q;
    logic       fault_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= '0;
            fault_q   <= 1'b0;
            int_en    <= 1'b0;
            fault_lat <= 1'b0;
        end else begin
            seen_q    <= {conn, bias, dis, fault};
            fault_q   <= fault;
            if (en_wr) int_en <= en_val;
            fault_lat <= (fault & ~fault_q) | (fault_lat & ~(en_wr & fault_clr));
        end
    end

    assign chg_evt = int_en && ({conn, bias, dis, fault} != seen_q);

    a_r10_fault_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |=> fault_lat);
endmodule

// File: rtl/phyreg_irq.sv
module phyreg_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cps,
    input  logic       loop_evt,
    input  logic       timeout_evt,
    input  logic       port_chg_any,
    input  logic       resume_any,
    input  logic       irq_wr,
    input  logic [7:0] wd,
    output logic       loop_f,
    output logic       pwr_fail_f,
    output logic       timeout_f,
    output logic       port_event_f,
    output logic       resume_en
);
    logic cps_q;
    logic evt_set;

    assign evt_set = port_chg_any | (resume_any & resume_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cps_q        <= 1'b0;
            loop_f       <= 1'b0;
            pwr_fail_f   <= 1'b1;
            timeout_f    <= 1'b0;
            port_event_f <= 1'b0;
            resume_en    <= 1'b0;
        end else begin
            cps_q        <= cps;
            loop_f       <= loop_evt | (loop_f & ~(irq_wr & wd[6]));
            pwr_fail_f   <= (cps_q & ~cps) | (pwr_fail_f & ~(irq_wr & wd[5]));
            timeout_f    <= timeout_evt | (timeout_f & ~(irq_wr & wd[4]));
            port_event_f <= evt_set | (port_event_f & ~(irq_wr & wd[3]));
            if (irq_wr) resume_en <= wd[2];
        end
    end

    a_r6_pwrfail_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(cps)) |=> pwr_fail_f);
    a_r7_loop_set: assert property (@(posedge clk) disable iff (!rst_n)
        loop_evt |=> loop_f);
    a_r11_event_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wr && wd[3] && !port_chg_any && !resume_any) |=> !port_event_f);
endmodule

// File: rtl/phy_cfg_regfile.sv
module phy_cfg_regfile
    import phyreg_pkg::*;
#(
    parameter int          NUM_PORTS  = 3,
    parameter int          PORT_W     = 4,
    parameter int          PAGE_W     = 3,
    parameter logic [23:0] VENDOR_ID  = 24'hA1B2C3,
    parameter logic [23:0] PRODUCT_ID = 24'h0D0E0F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             addr,
    input  logic                   wr_en,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    input  logic [5:0]             node_id,
    input  logic                   is_root,
    input  logic                   cable_pwr,
    input  logic                   lps,
    input  logic                   strap_contender,
    input  logic [2:0]             strap_pwr_class,
    input  logic                   loop_evt,
    input  logic                   timeout_evt,
    input  logic [2*NUM_PORTS-1:0] port_a_line,
    input  logic [2*NUM_PORTS-1:0] port_b_line,
    input  logic [NUM_PORTS-1:0]   port_child,
    input  logic [NUM_PORTS-1:0]   port_conn,
    input  logic [NUM_PORTS-1:0]   port_bias,
    input  logic [NUM_PORTS-1:0]   port_dis,
    input  logic [NUM_PORTS-1:0]   port_fault,
    input  logic [3*NUM_PORTS-1:0] port_speed,
    input  logic [NUM_PORTS-1:0]   port_resume,
    output logic [5:0]             gap_count,
    output logic                   contender,
    output logic [2:0]             pwr_class,
    output logic                   link_active,
    output logic                   bus_reset_req,
    output logic                   short_reset_req,
    output logic                   irq_port_event,
    output logic                   irq_pwr_fail,
    output logic                   irq_loop,
    output logic                   irq_timeout
);
    localparam logic [4:0] PORT_COUNT = 5'(NUM_PORTS);

    logic [PAGE_W-1:0]    page_sel;
    logic [PORT_W-1:0]    port_sel;
    logic                 link_ctrl;
    logic                 resume_en;
    logic                 win9_wr;
    logic [NUM_PORTS-1:0] int_en, fault_lat, chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_count <= 6'h3F;
            link_ctrl <= 1'b0;
            page_sel  <= '0;
            port_sel  <= '0;
        end else if (wr_en) begin
            if (addr == A_GAP)  gap_count <= wr_data[5:0];
            if (addr == A_LINK) link_ctrl <= wr_data[7];
            if (addr == A_SEL) begin
                page_sel <= wr_data[7:5];
                port_sel <= wr_data[PORT_W-1:0];
            end
        end
    end

    // strap values are captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            contender <= strap_contender;
            pwr_class <= strap_pwr_class;
        end else if (wr_en && addr == A_LINK) begin
            contender <= wr_data[6];
            pwr_class <= wr_data[2:0];
        end
    end

    assign link_active = link_ctrl & lps;
    assign win9_wr = wr_en && (addr == A_WIN9) && (page_sel == '0);

    phyreg_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n),
        .long_wr(wr_en && addr == A_GAP && wr_data[7]),
        .short_wr(wr_en && addr == A_IRQ && wr_data[7]),
        .long_req(bus_reset_req), .short_req(short_reset_req)
    );

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        phyreg_port_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .conn(port_conn[gp]), .bias(port_bias[gp]),
            .dis(port_dis[gp]), .fault(port_fault[gp]),
            .en_wr(win9_wr && port_sel == PORT_W'(gp)),
            .en_val(wr_data[4]), .fault_clr(wr_data[3]),
            .int_en(int_en[gp]), .fault_lat(fault_lat[gp]), .chg_evt(chg[gp])
        );
    end

    phyreg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cps(cable_pwr),
        .loop_evt(loop_evt), .timeout_evt(timeout_evt),
        .port_chg_any(|chg), .resume_any(|port_resume),
        .irq_wr(wr_en && addr == A_IRQ), .wd(wr_data),
        .loop_f(irq_loop), .pwr_fail_f(irq_pwr_fail), .timeout_f(irq_timeout),
        .port_event_f(irq_port_event), .resume_en(resume_en)
    );

    logic [7:0] stat0, stat1, win;
    logic       port_ok;

    always_comb begin
        stat0   = '0;
        stat1   = '0;
        port_ok = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_sel == PORT_W'(p)) begin
                port_ok = 1'b1;
                stat0 = {port_a_line[2*p +: 2], port_b_line[2*p +: 2], port_child[p],
                         port_conn[p], port_bias[p], port_dis[p]};
                stat1 = {port_speed[3*p +: 3], int_en[p], fault_lat[p], 3'b000};
            end
        end
    end

    always_comb begin
        win = '0;
        if (page_sel == PAGE_W'(0)) begin
            if (port_ok) begin
                if (addr[2:0] == 3'd0) win = stat0;
                if (addr[2:0] == 3'd1) win = stat1;
            end
        end else if (page_sel == PAGE_W'(1)) begin
            case (addr[2:0])
                3'd0:    win = 8'h01;
                3'd2:    win = VENDOR_ID[23:16];
                3'd3:    win = VENDOR_ID[15:8];
                3'd4:    win = VENDOR_ID[7:0];
                3'd5:    win = PRODUCT_ID[23:16];
                3'd6:    win = PRODUCT_ID[15:8];
                3'd7:    win = PRODUCT_ID[7:0];
                default: win = '0;
            endcase
        end
    end

    always_comb begin
        if (addr[3]) rd_data = win;
        else begin
            case (addr)
                A_IDENT: rd_data = {node_id, is_root, cable_pwr};
                A_GAP:   rd_data = {bus_reset_req, 1'b0, gap_count};
                A_CAPS:  rd_data = {3'b111, PORT_COUNT};
                A_SPEED: rd_data = 8'h40;
                A_LINK:  rd_data = {link_ctrl, contender, 3'b000, pwr_class};
                A_IRQ:   rd_data = {short_reset_req, irq_loop, irq_pwr_fail, irq_timeout,
                                    irq_port_event, resume_en, 2'b00};
                A_SEL:   rd_data = {page_sel, 1'b0, port_sel};
                default: rd_data = '0;
            endcase
        end
    end

    a_r3_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_GAP) |=> $stable(gap_count));
    a_r5_link_needs_lps: assert property (@(posedge clk) disable iff (!rst_n)
        !lps |-> !link_active);
endmodule

// File: tb/tb_phy_cfg_regfile.sv
module tb_phy_cfg_regfile;
    localparam int NP = 3;

    logic clk = 0, rst_n = 0;
    logic [3:0] addr = 0;
    logic wr_en = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic [5:0] node_id = 6'h15;
    logic is_root = 1, cable_pwr = 1, lps = 0;
    logic strap_contender = 1;
    logic [2:0] strap_pwr_class = 3'b101;
    logic loop_evt = 0, timeout_evt = 0;
    logic [2*NP-1:0] port_a_line = 0, port_b_line = 0;
    logic [NP-1:0] port_child = 0, port_conn = 0, port_bias = 0, port_dis = 0;
    logic [NP-1:0] port_fault = 0, port_resume = 0;
    logic [3*NP-1:0] port_speed = 0;
    logic [5:0] gap_count;
    logic contender, link_active, bus_reset_req, short_reset_req;
    logic [2:0] pwr_class;
    logic irq_port_event, irq_pwr_fail, irq_loop, irq_timeout;

    phy_cfg_regfile dut (.*);

    always #4 clk = ~clk;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       smp;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares with the design's read data
    always @(smp) begin
        chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1 ->smp;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'd1, 8'h3F, "R1 gap reset");
        rd(4'd5, 8'h20, "R1 irq reset");
        rd(4'd7, 8'h00, "R1 select reset");
        rd(4'd4, 8'h45, "R1 strap link reg");
        // R2 fixed locations
        rd(4'd0, 8'h57, "R2 ident");
        rd(4'd2, 8'hE3, "R2 caps");
        rd(4'd3, 8'h40, "R2 speed");
        rd(4'd6, 8'h00, "R2 reserved");
        // R3 gap and R4 long reset pulse
        wr(4'd1, 8'h95);
        chk({7'd0, bus_reset_req}, 8'd1, "R4 long pulse high");
        chk({7'd0, short_reset_req}, 8'd0, "R4 short idle");
        chk({2'd0, gap_count}, 8'h15, "R3 gap port");
        @(negedge clk);
        chk({7'd0, bus_reset_req}, 8'd0, "R4 long pulse ends");
        rd(4'd1, 8'h15, "R3 gap read");
        // R4 short reset
        wr(4'd5, 8'h80);
        chk({6'd0, bus_reset_req, short_reset_req}, 8'd1, "R4 short pulse");
        @(negedge clk);
        chk({7'd0, short_reset_req}, 8'd0, "R4 short ends");
        rd(4'd5, 8'h20, "R4 irq after cmd");
        // R5 link
        wr(4'd4, 8'hC5);
        chk({7'd0, link_active}, 8'd0, "R5 link without lps");
        lps = 1;
        #1 chk({7'd0, link_active}, 8'd1, "R5 link with lps");
        wr(4'd4, 8'h02);
        chk({contender, 4'd0, pwr_class}, 8'h02, "R5 contender class write");
        rd(4'd4, 8'h02, "R5 link read");
        // R6 power fail
        wr(4'd5, 8'h20);
        rd(4'd5, 8'h00, "R6 pwr fail cleared");
        @(negedge clk) cable_pwr = 0;
        rd(4'd5, 8'h20, "R6 pwr fail set");
        wr(4'd5, 8'h20);
        @(negedge clk) cable_pwr = 1;
        rd(4'd5, 8'h00, "R6 rise no set");
        // R7 loop/timeout
        @(negedge clk) loop_evt = 1;
        @(negedge clk) loop_evt = 0;
        rd(4'd5, 8'h40, "R7 loop set");
        @(negedge clk) timeout_evt = 1;
        @(negedge clk) timeout_evt = 0;
        rd(4'd5, 8'h50, "R7 timeout set");
        wr(4'd5, 8'h40);
        rd(4'd5, 8'h10, "R7 loop clear");
        wr(4'd5, 8'h00);
        rd(4'd5, 8'h10, "R7 zero write keeps");
        wr(4'd5, 8'h10);
        rd(4'd5, 8'h00, "R7 timeout clear");
        // R8/R9 page 0 port 1
        wr(4'd7, 8'h01);
        rd(4'd7, 8'h01, "R8 select read");
        port_a_line[3:2] = 2'b01; port_b_line[3:2] = 2'b10;
        port_child[1] = 1; port_conn[1] = 1; port_speed[5:3] = 3'b010;
        rd(4'd8, 8'h6C, "R9 status byte");
        rd(4'd9, 8'h40, "R9 speed byte");
        rd(4'd5, 8'h00, "R11 no event while disabled");
        // R10/R11
        wr(4'd9, 8'h10);
        rd(4'd9, 8'h50, "R10 int enable");
        @(negedge clk) port_bias[1] = 1;
        rd(4'd5, 8'h08, "R11 bias change event");
        rd(4'd8, 8'h6E, "R9 bias shown");
        wr(4'd5, 8'h08);
        rd(4'd5, 8'h00, "R11 event clear");
        @(negedge clk) port_conn[2] = 1;
        rd(4'd5, 8'h00, "R11 unenabled port ignored");
        @(negedge clk) port_fault[1] = 1;
        rd(4'd9, 8'h58, "R10 fault latched");
        rd(4'd5, 8'h08, "R11 fault event");
        wr(4'd9, 8'h18);
        rd(4'd9, 8'h50, "R10 fault cleared");
        wr(4'd5, 8'h08);
        rd(4'd5, 8'h00, "R11 clear again");
        // R11 resume
        wr(4'd5, 8'h04);
        @(negedge clk) port_resume[0] = 1;
        @(negedge clk) port_resume[0] = 0;
        rd(4'd5, 8'h0C, "R11 resume event");
        wr(4'd5, 8'h0C);
        rd(4'd5, 8'h04, "R11 resume clear");
        wr(4'd5, 8'h00);
        @(negedge clk) port_resume[2] = 1;
        @(negedge clk) port_resume[2] = 0;
        rd(4'd5, 8'h00, "R11 resume disabled");
        // R12 page 1
        wr(4'd7, 8'h20);
        rd(4'd8, 8'h01, "R12 compliance");
        rd(4'd9, 8'h00, "R12 reserved");
        rd(4'd10, 8'hA1, "R12 vendor hi");
        rd(4'd12, 8'hC3, "R12 vendor lo");
        rd(4'd13, 8'h0D, "R12 product hi");
        rd(4'd15, 8'h0F, "R12 product lo");
        // R13 zero reads
        wr(4'd7, 8'h03);
        rd(4'd8, 8'h00, "R13 port out of range");
        wr(4'd7, 8'h41);
        rd(4'd8, 8'h00, "R13 page 2");
        rd(4'd11, 8'h00, "R13 page 2 high");
        @(negedge clk);
        report();
    end
endmodule